// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one unsigned word by another over many clock cycles. A caller presents a dividend and a divisor together with a one-cycle start strobe. The block then works through a trial subtraction for every quotient bit and, when it has finished, raises a one-cycle completion strobe. At that point the quotient and the remainder are valid on their outputs.

Internally, the divisor sits in a register twice the word width. It is placed in the upper half and moves one place right after each step. The running remainder starts out as the dividend. Each step takes two cycles. In the first, the aligned divisor is subtracted across the full double width. In the second, a negative result is undone by adding the divisor back, and a quotient bit is shifted in: 0 when the subtraction was undone, 1 when it was kept. There are one more steps than the word has bits, so the step at the first alignment also produces its bit. A zero divisor gives a defined result and the block does not hang.

Top module: `restoring_divider`

## Requirements
- R1: After reset, `done` is 0 and both `quotient` and `remainder` are 0.
- R2: A `start` taken while the block is idle begins one division. `done` is later high for exactly one cycle.
- R3: For a nonzero divisor, `quotient` equals the integer part of `dividend / divisor` as unsigned values.
- R4: For a nonzero divisor, `remainder` equals `dividend - quotient * divisor` and is strictly less than the divisor.
- R5: A zero divisor gives a `quotient` with every bit set and a `remainder` equal to the dividend, and `done` still pulses.
- R6: A dividend smaller than the divisor gives a `quotient` of 0 and a `remainder` equal to the dividend.
- R7: A `start` that arrives while a division is running is ignored. The result delivered belongs to the operands that were accepted first.
- R8: After `done`, `quotient` and `remainder` hold their values until the next accepted `start`.
- R9: The running remainder never grows from one step to the next, and its upper half is zero before every trial subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | DATA_W | Unsigned dividend, sampled with `start` |
| divisor | input | DATA_W | Unsigned divisor, sampled with `start` |
| done | output | 1 | One-cycle strobe marking valid results |
| quotient | output | DATA_W | Unsigned quotient |
| remainder | output | DATA_W | Unsigned remainder |

## Verification
The bench builds the block with its default width of 32 bits. At that width the extreme operands are within reach: the all-ones dividend, divisor 1, divisor all ones, a divisor of zero, and dividends with only the top bit set. These exercise the full 33-step alignment and the double-width borrow. Pseudo-random pairs include divisors shifted down by varying amounts, so that quotients of many different lengths occur. The bench also raises a second start in the middle of a division and checks that the outputs are held after completion.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SUB     = 2'd1,
        ST_RESTORE = 2'd2,
        ST_DONE    = 2'd3
    } rdiv_state_e;

    // One-hot style command bundle from the controller to the datapath
    typedef struct packed {
        logic load;     // capture operands and clear the quotient
        logic trial;    // full-width trial subtraction
        logic settle;   // add back when negative, then shift quotient and divisor
    } rdiv_cmd_t;

    // Number of quotient-bit steps for a given word width
    function automatic int unsigned step_total(input int unsigned width);
        return width + 1;
    endfunction

endpackage

// File: rtl/rdiv_addsub.sv
module rdiv_addsub #(
    parameter int unsigned N = 64
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sub,
    output logic [N-1:0] sum,
    output logic         below
);
    localparam int unsigned EXT = N + 1;

    logic [EXT-1:0] a_ext;
    logic [EXT-1:0] b_ext;
    logic [EXT-1:0] full;

    always_comb begin
        a_ext = {1'b0, a};
        b_ext = sub ? ~{1'b0, b} : {1'b0, b};
        full  = a_ext + b_ext + {{(EXT-1){1'b0}}, sub};
        sum   = full[N-1:0];
        // On subtraction the extra bit is set exactly when a < b
        below = sub & full[EXT-1];
    end
endmodule

// File: rtl/rdiv_ctrl.sv
module rdiv_ctrl
    import rdiv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    output rdiv_cmd_t cmd,
    output logic      done
);
    localparam int unsigned STEPS = step_total(DATA_W);
    localparam int unsigned CNT_W = $clog2(STEPS) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    rdiv_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d     = state_q;
        cnt_d       = cnt_q;
        cmd.load    = 1'b0;
        cmd.trial   = 1'b0;
        cmd.settle  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd.load = 1'b1;
                    cnt_d    = '0;
                    state_d  = ST_SUB;
                end
            end
            ST_SUB: begin
                cmd.trial = 1'b1;
                state_d   = ST_RESTORE;
            end
            ST_RESTORE: begin
                cmd.settle = 1'b1;
                if (cnt_q == LAST) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d   = cnt_q + 1'b1;
                    state_d = ST_SUB;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign done = (state_q == ST_DONE);

    // R2: completion strobe lasts a single cycle
    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: completion only follows the final settle step
    assert_done_after_settle_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state_q) == ST_RESTORE);

    // R7: no new load while a division is running
    assert_no_reload_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> !cmd.load);

    // Step counter stays inside the step range
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
endmodule

// File: rtl/rdiv_datapath.sv
module rdiv_datapath
    import rdiv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  rdiv_cmd_t         cmd,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder
);
    localparam int unsigned WIDE = 2 * DATA_W;

    logic [WIDE-1:0]   rem_q;
    logic [WIDE-1:0]   dsr_q;
    logic [DATA_W-1:0] quo_q;
    logic              neg_q;

    logic [WIDE-1:0] alu_sum;
    logic            alu_below;

    rdiv_addsub #(.N(WIDE)) u_alu (
        .a     (rem_q),
        .b     (dsr_q),
        .sub   (cmd.trial),
        .sum   (alu_sum),
        .below (alu_below)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            dsr_q <= '0;
            quo_q <= '0;
            neg_q <= 1'b0;
        end else if (cmd.load) begin
            rem_q <= {{DATA_W{1'b0}}, dividend};
            dsr_q <= {divisor, {DATA_W{1'b0}}};
            quo_q <= '0;
            neg_q <= 1'b0;
        end else if (cmd.trial) begin
            rem_q <= alu_sum;
            neg_q <= alu_below;
        end else if (cmd.settle) begin
            if (neg_q) begin
                rem_q <= alu_sum;
            end
            quo_q <= {quo_q[DATA_W-2:0], ~neg_q};
            dsr_q <= dsr_q >> 1;
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q[DATA_W-1:0];

    // R9: upper half of the running remainder is clear before each trial
    assert_rem_upper_clear_R9: assert property (@(posedge clk) disable iff (rst)
        cmd.trial |-> rem_q[WIDE-1:DATA_W] == '0);

    // R9: a full step never increases the running remainder
    assert_rem_nonincreasing_R9: assert property (@(posedge clk) disable iff (rst)
        cmd.settle |=> rem_q <= $past(rem_q, 2));

    // R3: kept trial shifts in a one, undone trial shifts in a zero
    assert_qbit_one_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.settle && !neg_q) |=> quo_q[0]);
    assert_qbit_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd.settle && neg_q) |=> !quo_q[0]);
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import rdiv_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] dividend,
    input  logic [DATA_W-1:0] divisor,
    output logic              done,
    output logic [DATA_W-1:0] quotient,
    output logic [DATA_W-1:0] remainder
);
    rdiv_cmd_t cmd;

    rdiv_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .cmd   (cmd),
        .done  (done)
    );

    rdiv_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // R8: results stay put between completion and the next load
    assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(done) && !cmd.load) |-> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/restoring_divider_bench.sv
module restoring_divider_bench;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    restoring_divider #(.DATA_W(W)) u_restoring_divider (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .done      (done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done(input string req);
        int i;
        for (i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s actual=no_done expected=done", req);
        end
    endtask

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic run_one(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] eq, er;
        if (b == '0) begin
            eq = '1;
            er = a;
        end else begin
            eq = a / b;
            er = a % b;
        end
        issue(a, b);
        wait_done(req);
        check(req, quotient, eq);
        check(req, remainder, er);
        @(negedge clk);
        check({req, "_R2_pulse"}, {31'b0, done}, 32'd0);
    endtask

    task automatic test_reset();
        check("R1_done", {31'b0, done}, 32'd0);
        check("R1_quotient", quotient, 32'd0);
        check("R1_remainder", remainder, 32'd0);
    endtask

    task automatic test_basic();
        run_one("R3_R4_74_8", 32'd74, 32'd8);
        run_one("R3_R4_22_2", 32'd22, 32'd2);
        run_one("R3_R4_max_1", 32'hFFFF_FFFF, 32'd1);
        run_one("R3_R4_max_max", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_one("R3_R4_top_3", 32'h8000_0000, 32'd3);
        run_one("R3_R4_big_div", 32'hFFFF_FFFF, 32'h8000_0000);
    endtask

    task automatic test_zero_div();
        run_one("R5_zero_div", 32'h1234_5678, 32'd0);
        run_one("R5_zero_both", 32'd0, 32'd0);
    endtask

    task automatic test_small_dividend();
        run_one("R6_3_7", 32'd3, 32'd7);
        run_one("R6_0_5", 32'd0, 32'd5);
        run_one("R6_near", 32'h7FFF_FFFE, 32'h7FFF_FFFF);
    endtask

    task automatic test_random();
        logic [W-1:0] x = 32'h2468_ACE1;
        logic [W-1:0] a, b;
        for (int i = 0; i < 40; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            a = x;
            x = x * 32'd1664525 + 32'd1013904223;
            b = x >> x[4:0];
            run_one("R3_R4_random", a, b);
        end
    endtask

    task automatic test_busy_start();
        issue(32'd1000, 32'd7);
        repeat (10) @(negedge clk);
        dividend = 32'd999_999;
        divisor  = 32'd3;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        wait_done("R7_busy");
        check("R7_quotient", quotient, 32'd142);
        check("R7_remainder", remainder, 32'd6);
    endtask

    task automatic test_hold();
        run_one("R8_setup", 32'd500, 32'd9);
        dividend = 32'hDEAD_BEEF;
        divisor  = 32'd17;
        repeat (12) @(negedge clk);
        check("R8_quotient_hold", quotient, 32'd55);
        check("R8_remainder_hold", remainder, 32'd5);
        check("R8_no_done", {31'b0, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_basic();
        test_zero_div();
        test_small_dividend();
        test_random();
        test_busy_start();
        test_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule